// File: doc/BRIEF.md
# Two-Beat Masked Window Write Driver

This block places one processor write to an I/O window onto the data path of a shared system bus. A write has a 256-bit payload, made of eight 32-bit longwords, and eight valid bits. Valid bit *i* marks longword *i* as modified. The driver takes the write through a valid/ready handshake and holds it in its own registers. It then spends two consecutive data cycles on the bus: the whole payload goes out in the first cycle, and the valid bits go out alone in the second.

The receiving I/O port uses the second cycle to choose which longwords of the first cycle go into the packet it sends downstream. The byte-enable information therefore does not travel on wires of its own beside the data. It is time-multiplexed onto the same data lines, one bit per longword. The driver accepts a new write only while it is idle, so each write takes one handshake cycle plus two bus data cycles.

Top module: `wwin_wr_driver`

## Requirements
- R1: While reset is active, and until the second clock edge after `rst_n` is released, `wr_ready` and `bus_dvalid` are 0 and `bus_data` is all zero. From the following cycle on, with no write offered, `wr_ready` is 1.
- R2: A write is accepted at a clock edge where both `wr_valid` and `wr_ready` are 1. `wr_ready` is 0 in the two cycles that follow that edge.
- R3: In the cycle after the accepting edge, the bus shows the first data cycle: `bus_dvalid`=1, `bus_second`=0, and `bus_data` equals the `wr_data` that was accepted. Longword *i* is `bus_data[32*i+31:32*i]`.
- R4: In the cycle after the first data cycle, the bus shows the second data cycle: `bus_dvalid`=1 and `bus_second`=1. `bus_data[7:0]` holds the accepted `wr_mask`, with bit *i* standing for longword *i*, and `bus_data[255:8]` is zero.
- R5: In the cycle after the second data cycle, `bus_dvalid` is 0 and `wr_ready` is 1 again.
- R6: `wr_valid`, `wr_data` and `wr_mask` have no effect while `wr_ready` is 0. The transfer carries the values that were accepted, and no extra transfer follows.
- R7: A write whose `wr_mask` is all zero is still transferred in both data cycles, and its second cycle shows `bus_data` all zero.
- R8: Whenever `bus_dvalid` is 0, `bus_data` is all zero and `bus_second` is 0.
- R9: Changes to `wr_data` and `wr_mask` after the accepting edge do not alter either data cycle of that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| wr_valid | input | 1 | A write is offered |
| wr_ready | output | 1 | Driver is idle and will accept the offered write |
| wr_data | input | 256 | Write payload, eight 32-bit longwords |
| wr_mask | input | 8 | Per-longword valid bits, bit i for longword i |
| bus_dvalid | output | 1 | A data cycle is being driven on the bus |
| bus_second | output | 1 | 0: payload cycle, 1: valid-bit cycle |
| bus_data | output | 256 | Bus data lines |

## Verification
The hardest situation to reach is a write offered, or changed, while the driver is still busy with the previous one. That is the point where a wrong enable on the holding registers would corrupt the valid-bit cycle that is already on its way. The stimulus reaches it in two ways. It keeps `wr_valid` high with fresh payload and mask values through both busy cycles. It also scrambles `wr_data` and `wr_mask` on the cycle right after each accepting edge. A continuous stream of back-to-back requests then tests that the driver goes back to idle on exactly the cycle after the second data cycle.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BEAT1 = 2'd1,
    ST_BEAT2 = 2'd2
  } wwd_state_e;

endpackage

// File: rtl/wwd_rst_sync.sv
module wwd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/wwd_seq.sv
module wwd_seq
  import wwd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic cap_en,
  output logic beat_first,
  output logic beat_second
);

  wwd_state_e state_q;
  wwd_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_BEAT1;
      ST_BEAT1: state_d = ST_BEAT2;
      ST_BEAT2: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign req_ready   = rst_n && (state_q == ST_IDLE);
  assign cap_en      = req_ready && req_valid;
  assign beat_first  = (state_q == ST_BEAT1);
  assign beat_second = (state_q == ST_BEAT2);

  // R2: the handshake closes for the whole transfer
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> !req_ready && beat_first);

  // R4: the valid-bit cycle always follows the payload cycle
  p_beat2_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_first |=> beat_second && !req_ready);

  // R5: back to idle right after the second cycle
  p_idle_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_second |=> req_ready && !beat_first && !beat_second);

  p_beats_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat_first && beat_second));

endmodule

// File: rtl/wwd_hold.sv
module wwd_hold #(
  parameter int LW_W   = 32,
  parameter int NUM_LW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap_en,
  input  logic [LW_W*NUM_LW-1:0]   d_in,
  input  logic [NUM_LW-1:0]        m_in,
  output logic [LW_W*NUM_LW-1:0]   d_q,
  output logic [NUM_LW-1:0]        m_q
);

  for (genvar g = 0; g < NUM_LW; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q[g*LW_W +: LW_W] <= '0;
      end else if (cap_en) begin
        d_q[g*LW_W +: LW_W] <= d_in[g*LW_W +: LW_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0;
    end else if (cap_en) begin
      m_q <= m_in;
    end
  end

  // R6: held values change only on a capture
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(d_q) && $stable(m_q));

endmodule

// File: rtl/wwd_beat_mux.sv
module wwd_beat_mux #(
  parameter int LW_W   = 32,
  parameter int NUM_LW = 8
) (
  input  logic                     beat_first,
  input  logic                     beat_second,
  input  logic [LW_W*NUM_LW-1:0]   d_q,
  input  logic [NUM_LW-1:0]        m_q,
  output logic [LW_W*NUM_LW-1:0]   bus_out
);

  localparam int DATA_W = LW_W * NUM_LW;

  logic [DATA_W-1:0] mask_ext;
  assign mask_ext = {{(DATA_W-NUM_LW){1'b0}}, m_q};

  for (genvar g = 0; g < NUM_LW; g++) begin : g_lane
    always_comb begin
      if (beat_first) begin
        bus_out[g*LW_W +: LW_W] = d_q[g*LW_W +: LW_W];
      end else if (beat_second) begin
        bus_out[g*LW_W +: LW_W] = mask_ext[g*LW_W +: LW_W];
      end else begin
        bus_out[g*LW_W +: LW_W] = '0;
      end
    end
  end

endmodule

// File: rtl/wwin_wr_driver.sv
module wwin_wr_driver #(
  parameter int LW_W       = 32,
  parameter int NUM_LW     = 8,
  parameter int RST_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic [LW_W*NUM_LW-1:0]   wr_data,
  input  logic [NUM_LW-1:0]        wr_mask,
  output logic                     bus_dvalid,
  output logic                     bus_second,
  output logic [LW_W*NUM_LW-1:0]   bus_data
);

  localparam int DATA_W = LW_W * NUM_LW;

  logic              srst_n;
  logic              cap_en;
  logic              beat_first;
  logic              beat_second;
  logic [DATA_W-1:0] d_q;
  logic [NUM_LW-1:0] m_q;

  wwd_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  wwd_seq u_seq (
    .clk         (clk),
    .rst_n       (srst_n),
    .req_valid   (wr_valid),
    .req_ready   (wr_ready),
    .cap_en      (cap_en),
    .beat_first  (beat_first),
    .beat_second (beat_second)
  );

  wwd_hold #(.LW_W(LW_W), .NUM_LW(NUM_LW)) u_hold (
    .clk    (clk),
    .rst_n  (srst_n),
    .cap_en (cap_en),
    .d_in   (wr_data),
    .m_in   (wr_mask),
    .d_q    (d_q),
    .m_q    (m_q)
  );

  wwd_beat_mux #(.LW_W(LW_W), .NUM_LW(NUM_LW)) u_mux (
    .beat_first  (beat_first),
    .beat_second (beat_second),
    .d_q         (d_q),
    .m_q         (m_q),
    .bus_out     (bus_data)
  );

  assign bus_dvalid = beat_first || beat_second;
  assign bus_second = beat_second;

  // R3: payload cycle carries what was accepted
  p_payload_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_valid && wr_ready) |=> bus_dvalid && !bus_second && (bus_data == $past(wr_data)));

  // R4: mask cycle carries the accepted mask, upper lines quiet
  p_mask_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_valid && wr_ready) |=> ##1 bus_second &&
      (bus_data[NUM_LW-1:0] == $past(wr_mask, 2)) && (bus_data[DATA_W-1:NUM_LW] == '0));

  // R8: idle bus is quiet
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!srst_n)
    !bus_dvalid |-> (bus_data == '0) && !bus_second);

endmodule

// File: tb/wwin_wr_driver_tb.sv
`timescale 1ns/100ps
module wwin_wr_driver_tb;

  localparam int DW = 256;
  localparam int MW = 8;

  logic          clk;
  logic          rst_n;
  logic          wr_valid;
  logic          wr_ready;
  logic [DW-1:0] wr_data;
  logic [MW-1:0] wr_mask;
  logic          bus_dvalid;
  logic          bus_second;
  logic [DW-1:0] bus_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string scen = "R1";

  wwin_wr_driver u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_data    (wr_data),
    .wr_mask    (wr_mask),
    .bus_dvalid (bus_dvalid),
    .bus_second (bus_second),
    .bus_data   (bus_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ---------------- reference model ----------------
  logic [DW-1:0] q_data[$];
  bit            q_sec[$];
  bit            cur_v, cur_s;
  logic [DW-1:0] cur_d;
  int            rs_cnt;
  bit            exp_rdy;

  task automatic chk(string what, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s/%s] act=%h exp=%h", what, req, scen, act, exp);
    end
  endtask

  initial begin
    rs_cnt = 0; cur_v = 0; cur_s = 0; cur_d = '0;
  end

  always @(negedge clk) begin
    string rq;
    if (!rst_n) begin
      rs_cnt = 0; cur_v = 0; cur_s = 0; cur_d = '0;
      q_data.delete(); q_sec.delete();
    end
    exp_rdy = (rs_cnt >= 2) && !cur_v && (q_data.size() == 0);
    rq = (rs_cnt < 2) ? "R1" : (cur_v ? "R2" : "R5");
    chk("wr_ready", rq, DW'(wr_ready), DW'(exp_rdy));
    rq = (rs_cnt < 2) ? "R1" : (!cur_v ? "R8" : (cur_s ? "R4" : "R3"));
    chk("bus_dvalid", rq, DW'(bus_dvalid), DW'(cur_v));
    chk("bus_second", rq, DW'(bus_second), DW'(cur_s));
    chk("bus_data", rq, bus_data, cur_d);
    if (rst_n) begin
      if (exp_rdy && wr_valid) begin
        q_data.push_back(wr_data);          q_sec.push_back(1'b0);
        q_data.push_back(DW'(wr_mask));     q_sec.push_back(1'b1);
      end
      if (q_data.size() != 0) begin
        cur_v = 1'b1;
        cur_d = q_data.pop_front();
        cur_s = q_sec.pop_front();
      end else begin
        cur_v = 1'b0; cur_s = 1'b0; cur_d = '0;
      end
      if (rs_cnt < 2) rs_cnt++;
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired [%s] act=%0d exp<=20000", scen, cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [DW-1:0] rnd_data();
    logic [DW-1:0] v;
    for (int i = 0; i < DW/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // offer a write, wait for acceptance; optionally keep pestering while busy
  task automatic send(logic [DW-1:0] d, logic [MW-1:0] m, int busy_hold);
    bit r;
    wr_valid = 1'b1; wr_data = d; wr_mask = m;
    forever begin
      @(negedge clk); r = wr_ready;
      @(posedge clk); #1;
      if (r) break;
    end
    // R9: scramble inputs right after acceptance
    wr_data = rnd_data(); wr_mask = MW'($urandom);
    wr_valid = (busy_hold > 0);
    for (int i = 0; i < busy_hold; i++) begin
      // R6: valid held high with new values while busy
      wr_data = rnd_data(); wr_mask = MW'($urandom);
      @(posedge clk); #1;
    end
    wr_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0; wr_mask = '0;
    scen = "R1";
    idle(3);
    rst_n = 1'b1;
    idle(6);

    scen = "R3_R4";
    for (int k = 0; k < 6; k++) begin
      send(rnd_data(), MW'($urandom), 0);
      idle(3);
    end

    scen = "R7";
    send(rnd_data(), 8'h00, 0);
    idle(4);
    scen = "R4_full";
    send(rnd_data(), 8'hFF, 0);
    idle(4);
    scen = "R4_onehot";
    for (int b = 0; b < MW; b++) begin
      send(rnd_data(), MW'(1) << b, 0);
      idle(1);
    end
    idle(3);

    scen = "R6";
    for (int k = 0; k < 5; k++) begin
      send(rnd_data(), MW'($urandom), 2);
      idle(3);
    end

    scen = "R9";
    for (int k = 0; k < 4; k++) send(rnd_data(), MW'($urandom), 0);
    idle(4);

    scen = "R2_R5";
    for (int k = 0; k < 20; k++) send(rnd_data(), MW'($urandom), 0);
    scen = "R7_stream";
    for (int k = 0; k < 3; k++) send('0, 8'h00, 0);
    idle(5);

    scen = "R1";
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    scen = "R3_R4";
    send(rnd_data(), 8'hA5, 0);
    idle(5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule